// File: doc/BRIEF.md
# Single-Precision Float Compare to Integer Flags

This unit orders two IEEE 754 single-precision values and reports the outcome as ordinary integer condition flags: zero (Z), negative (N), overflow (V) and carry (C). Because the encoding is chosen so that integer condition tests read float ordering correctly, a branch or conditional instruction can act on the flags in the very next instruction. No separate floating-point flag register is involved. Both operands arrive as raw 32-bit words from the integer register file, together with a valid strobe.

The unit compares signed zeros, denormals, infinities and NaNs correctly. Every NaN is quiet. An unordered comparison sets a dedicated indicator and a distinct flag pattern, and it raises no exception. The unit has no exception output. The flags, the write enable and the unordered indicator are registered, so they appear one clock after the strobe. The flags then hold until the next strobe.

Top module: `fcmpFlagUnit`

## Requirements
- R1: While `rstN` is low, and after its release until the first strobe, `flagsOut` is 4'b0000 and both `flagWe` and `unordered` are 0.
- R2: `flagWe` is 1 in exactly the cycle after a cycle with `opValid` high, and 0 after any cycle with `opValid` low.
- R3: The flag vector has the bit positions C=bit0, Z=bit1, N=bit2, V=bit3. When A equals B, `flagsOut` is 4'b0010 (Z only), and +0 compared with -0 counts as equal.
- R4: When A is less than B, `flagsOut` is 4'b0101 (N and C set, Z and V clear). With this pattern the signed-less test (N!=V) and the unsigned-lower test (C) are both true.
- R5: When A is greater than B, `flagsOut` is 4'b0000.
- R6: When either operand is a NaN (exponent all ones with a nonzero fraction), `unordered` is 1 and `flagsOut` is 4'b1000 (V only). With this pattern the eq test (Z), the ge test (N==V) and the ls test (C|Z) are all false. Otherwise `unordered` is 0.
- R7: Denormal operands are ordered by their true values and are never treated as zero unless every bit other than the sign is 0.
- R8: Infinities order beyond every finite value of the same sign, and two equal infinities compare equal.
- R9: In cycles after `opValid` was low, `flagsOut` and `unordered` keep their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operands valid, compare requested |
| opA | input | 32 | First operand, single-precision bit pattern |
| opB | input | 32 | Second operand, single-precision bit pattern |
| flagsOut | output | 4 | Registered flags {V,N,Z,C} |
| flagWe | output | 1 | Flag write enable for the status register |
| unordered | output | 1 | Registered indicator that a NaN was involved |

## Verification
The bench builds the unit with its default format parameters: an 8-bit exponent and a 23-bit fraction, which is the single-precision layout. With these values the bench can write exact boundary patterns: the smallest denormal, the largest denormal against the smallest normal, the largest finite value against infinity, and quiet NaNs with either sign. It can also compare the two signed zeros. After each compare it drives idle cycles with changed operands, which makes the hold behaviour and the one-cycle write-enable pulse visible at the ports.

// File: rtl/fcmpPkg.sv
package fcmpPkg;

  localparam int FLAG_W = 4;
  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;

  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } relation_t;

  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;

  function automatic logic [FLAG_W-1:0] relToFlags(input relation_t rel);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (rel)
      REL_EQ: f[FLAG_Z] = 1'b1;
      REL_LT: begin
        f[FLAG_N] = 1'b1;
        f[FLAG_C] = 1'b1;
      end
      REL_UN: f[FLAG_V] = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/fcmpOperandClass.sv
module fcmpOperandClass #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output logic                 isNan,
  output logic                 isZero,
  output logic [EXP_W+MAN_W:0] orderKey
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SIGN_BIT = WORD_W - 1;

  logic expAllOnes;
  logic fracNonZero;

  always_comb begin
    expAllOnes  = &word[SIGN_BIT-1:MAN_W];
    fracNonZero = |word[MAN_W-1:0];
    isNan       = expAllOnes && fracNonZero;
    isZero      = ~|word[SIGN_BIT-1:0];
    // Map sign-magnitude onto a monotonic unsigned key.
    if (word[SIGN_BIT]) orderKey = ~word;
    else                orderKey = {1'b1, word[SIGN_BIT-1:0]};
  end

endmodule

// File: rtl/fcmpControl.sv
module fcmpControl
  import fcmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  output ctrlStrobe_t strobe,
  output logic        flagWe
);

  always_comb strobe.capture = opValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagWe <= 1'b0;
    else       flagWe <= opValid;
  end

  a_r2_we_after_valid: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> flagWe);
  a_r2_we_low_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !flagWe);

endmodule

// File: rtl/fcmpDatapath.sv
module fcmpDatapath
  import fcmpPkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  output logic [FLAG_W-1:0]    flagsOut,
  output logic                 unordered
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int NUM_OPS = 2;

  logic [WORD_W-1:0] opWord [NUM_OPS];
  logic              opNan  [NUM_OPS];
  logic              opZero [NUM_OPS];
  logic [WORD_W-1:0] opKey  [NUM_OPS];

  always_comb begin
    opWord[0] = opA;
    opWord[1] = opB;
  end

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_class
    fcmpOperandClass #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .word    (opWord[i]),
      .isNan   (opNan[i]),
      .isZero  (opZero[i]),
      .orderKey(opKey[i])
    );
  end

  relation_t relNext;

  always_comb begin
    if (opNan[0] || opNan[1])         relNext = REL_UN;
    else if (opZero[0] && opZero[1])  relNext = REL_EQ;
    else if (opKey[0] == opKey[1])    relNext = REL_EQ;
    else if (opKey[0] < opKey[1])     relNext = REL_LT;
    else                              relNext = REL_GT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsOut  <= '0;
      unordered <= 1'b0;
    end else if (strobe.capture) begin
      flagsOut  <= relToFlags(relNext);
      unordered <= (relNext == REL_UN);
    end
  end

  a_r6_unordered_pattern: assert property (@(posedge clk) disable iff (!rstN)
    unordered |-> (flagsOut == 4'b1000));
  a_r3_zero_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut[FLAG_Z] |-> (flagsOut == 4'b0010 && !unordered));
  a_r4_less_pair: assert property (@(posedge clk) disable iff (!rstN)
    flagsOut[FLAG_N] |-> (flagsOut[FLAG_C] && !flagsOut[FLAG_V]));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(flagsOut) && $stable(unordered)));

endmodule

// File: rtl/fcmpFlagUnit.sv
module fcmpFlagUnit
  import fcmpPkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  output logic [FLAG_W-1:0]    flagsOut,
  output logic                 flagWe,
  output logic                 unordered
);

  ctrlStrobe_t strobe;

  fcmpControl u_control (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .strobe (strobe),
    .flagWe (flagWe)
  );

  fcmpDatapath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .flagsOut (flagsOut),
    .unordered(unordered)
  );

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (flagsOut == 4'b0000 && !flagWe && !unordered));

endmodule

// File: tb/fcmpFlagUnit_bench.sv
module fcmpFlagUnit_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 5000;

  localparam logic [3:0] F_EQ = 4'b0010;
  localparam logic [3:0] F_LT = 4'b0101;
  localparam logic [3:0] F_GT = 4'b0000;
  localparam logic [3:0] F_UN = 4'b1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  flagsOut;
  logic        flagWe;
  logic        unordered;

  int testsRun = 0;
  int testsFailed = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  fcmpFlagUnit u_fcmpFlagUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opA(opA), .opB(opB),
    .flagsOut(flagsOut), .flagWe(flagWe), .unordered(unordered)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > WATCHDOG_CYCLES && !finished) begin
      testsFailed = testsFailed + 1;
      $display("FAIL watchdog: actual %0d cycles, expected at most %0d", cycleCount, WATCHDOG_CYCLES);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One compare, then one idle cycle with scrambled operands (R2, R9).
  task automatic doCompare(input string req, input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] expFlags, input logic expUn);
    @(negedge clk);
    opA = a; opB = b; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check({req, " flags"}, {28'd0, flagsOut}, {28'd0, expFlags});
    check({req, " unordered (R6)"}, {31'd0, unordered}, {31'd0, expUn});
    check("R2 we pulse", {31'd0, flagWe}, 32'd1);
    opA = ~a; opB = 32'h7FC0_0000;
    @(negedge clk);
    check("R2 we low idle", {31'd0, flagWe}, 32'd0);
    check("R9 flags hold", {28'd0, flagsOut}, {28'd0, expFlags});
    check("R9 unordered hold", {31'd0, unordered}, {31'd0, expUn});
  endtask

  task automatic testReset();
    #(CLK_PERIOD/4);
    check("R1 flags in reset", {28'd0, flagsOut}, 32'd0);
    check("R1 we in reset", {31'd0, flagWe}, 32'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    opA = 32'h7FC0_0000;
    @(negedge clk);
    check("R1 flags after release", {28'd0, flagsOut}, 32'd0);
    check("R1 unordered after release", {31'd0, unordered}, 32'd0);
    check("R1 we after release", {31'd0, flagWe}, 32'd0);
  endtask

  task automatic testEqual();
    doCompare("R3 one eq one", 32'h3F80_0000, 32'h3F80_0000, F_EQ, 1'b0);
    doCompare("R3 +0 eq -0", 32'h0000_0000, 32'h8000_0000, F_EQ, 1'b0);
    doCompare("R3 -0 eq +0", 32'h8000_0000, 32'h0000_0000, F_EQ, 1'b0);
  endtask

  task automatic testOrder();
    doCompare("R4 1 lt 2", 32'h3F80_0000, 32'h4000_0000, F_LT, 1'b0);
    doCompare("R5 2 gt 1", 32'h4000_0000, 32'h3F80_0000, F_GT, 1'b0);
    doCompare("R4 -1 lt 1", 32'hBF80_0000, 32'h3F80_0000, F_LT, 1'b0);
    doCompare("R4 -2 lt -1", 32'hC000_0000, 32'hBF80_0000, F_LT, 1'b0);
    doCompare("R5 -1 gt -2", 32'hBF80_0000, 32'hC000_0000, F_GT, 1'b0);
  endtask

  task automatic testDenormal();
    doCompare("R7 min denorm gt 0", 32'h0000_0001, 32'h0000_0000, F_GT, 1'b0);
    doCompare("R7 denorm 2 gt 1", 32'h0000_0002, 32'h0000_0001, F_GT, 1'b0);
    doCompare("R7 neg denorm lt 0", 32'h8000_0001, 32'h0000_0000, F_LT, 1'b0);
    doCompare("R7 max denorm lt min normal", 32'h007F_FFFF, 32'h0080_0000, F_LT, 1'b0);
  endtask

  task automatic testInfinity();
    doCompare("R8 +inf gt max", 32'h7F80_0000, 32'h7F7F_FFFF, F_GT, 1'b0);
    doCompare("R8 -inf lt -max", 32'hFF80_0000, 32'hFF7F_FFFF, F_LT, 1'b0);
    doCompare("R8 inf eq inf", 32'h7F80_0000, 32'h7F80_0000, F_EQ, 1'b0);
  endtask

  task automatic testNan();
    doCompare("R6 nan vs one", 32'h7FC0_0000, 32'h3F80_0000, F_UN, 1'b1);
    doCompare("R6 one vs neg nan", 32'h3F80_0000, 32'hFFFF_FFFF, F_UN, 1'b1);
    doCompare("R6 nan vs nan", 32'h7F80_0001, 32'h7F80_0001, F_UN, 1'b1);
    doCompare("R6 cleared after ordered", 32'h0000_0000, 32'h3F80_0000, F_LT, 1'b0);
  endtask

  initial begin
    testReset();
    testEqual();
    testOrder();
    testDenormal();
    testInfinity();
    testNan();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule